// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block collects eight interrupt request lines from peripherals and decides which of them the processor should service next. Requests are held in a pending record. Request line 0 ranks highest and line 7 lowest, in a fixed order. The block drives one interrupt line to the processor. When the processor acknowledges, the block returns a vector byte that names the winning line. The processor uses that byte to select the handler routine.

An in-service record lists the handlers that have started and not yet finished. A new request reaches the processor only if it ranks strictly above every entry in that record, so handlers nest by priority. An end-of-interrupt pulse closes the highest-priority open entry. A small write port sets the vector base and the per-line mask.

Top module: `prio_vec_irq_ctrl`

## Requirements
- R1: After a synchronous reset: `irq_o` and `vec_vld_o` are 0, `vec_o` is 0, nothing is pending or in service, no line is masked, and the vector base is 0.
- R2: A high level on `req_i[n]` in any cycle sets the pending bit of line n. The bit stays set until line n is acknowledged, even if the request drops.
- R3: Among the pending, unmasked lines, the one with the lowest index wins.
- R4: `irq_o` is high exactly when a pending unmasked line exists and its winner index is strictly lower than the lowest in-service index, or nothing is in service. A request at the same rank as an in-service line, or a lower rank, does not raise it.
- R5: When `ack_i` is high in a cycle where `irq_o` is high, `vec_vld_o` is high in the next cycle. In that cycle `vec_o` equals {base[4:0], winner index[2:0]}, with the base in bits 7:3.
- R6: At that same acknowledge edge, the winner's pending bit is cleared and its in-service bit is set.
- R7: `ack_i` while `irq_o` is low produces no vector and changes neither the pending nor the in-service record.
- R8: An `eoi_i` pulse clears only the lowest-index set in-service bit. If both arrive in one cycle, the end-of-interrupt acts on the record before the acknowledge adds its entry.
- R9: A masked line still becomes pending but never raises `irq_o`. Clearing its mask bit later lets it compete normally.
- R10: With `cfg_we_i` high, `cfg_sel_i`=0 writes `cfg_wdata_i` into the mask (bit n = 1 masks line n). `cfg_sel_i`=1 writes `cfg_wdata_i[4:0]` into the vector base, and bits 7:5 have no effect. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Peripheral request lines, level sampled each cycle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Configuration target: 0 mask, 1 vector base |
| cfg_wdata_i | input | 8 | Configuration write data |
| ack_i | input | 1 | Processor acknowledge |
| eoi_i | input | 1 | End-of-interrupt pulse |
| irq_o | output | 1 | Interrupt line to the processor |
| vec_o | output | 8 | Vector byte of the last acknowledged line |
| vec_vld_o | output | 1 | Vector valid, high for one cycle after an accepted acknowledge |

## Verification
The bench targets these corner cases:
- A request at the same rank as the open handler. A design that compared with less-or-equal would preempt itself.
- A short request pulse that has dropped before the acknowledge. A design that reflects `req_i` directly would lose it.
- An acknowledge with nothing to serve. A wrong design would emit a vector or corrupt the in-service record.
- End-of-interrupt with nested handlers open. A design that cleared every bit, or the wrong bit, would re-admit or block the wrong lines.
- A masked line that is pending. It must stay silent until it is unmasked, then win if it ranks highest.
- Writes to the base with the upper data bits set. A wrong design would corrupt the vector.

A random mix of these inputs runs against a model of the requirements.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    localparam int unsigned LINES  = 8;
    localparam int unsigned IDX_W  = $clog2(LINES);
    localparam int unsigned VEC_W  = 8;
    localparam int unsigned BASE_W = VEC_W - IDX_W;

    typedef logic [LINES-1:0]  line_vec_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [BASE_W-1:0] base_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        logic hit;
        idx_t idx;
    } pick_t;

    typedef enum logic {
        CFG_MASK = 1'b0,
        CFG_BASE = 1'b1
    } cfg_sel_e;

    // Lowest set index wins (index 0 is the top rank).
    function automatic pick_t first_set(input line_vec_t v);
        pick_t r;
        r = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = idx_t'(i);
            end
        end
        return r;
    endfunction

    function automatic line_vec_t one_hot(input logic en, input idx_t i);
        line_vec_t r;
        r = '0;
        if (en) r[i] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pvic_cfg.sv
module pvic_cfg
    import pvic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we_i,
    input  cfg_sel_e  sel_i,
    input  vec_t      wdata_i,
    output line_vec_t mask_o,
    output base_t     base_o
);
    line_vec_t mask_q;
    base_t     base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            base_q <= '0;
        end else if (we_i) begin
            case (sel_i)
                CFG_MASK: mask_q <= wdata_i[LINES-1:0];
                CFG_BASE: base_q <= wdata_i[BASE_W-1:0];
                default:  ;
            endcase
        end
    end

    assign mask_o = mask_q;
    assign base_o = base_q;
endmodule

// File: rtl/pvic_resolve.sv
module pvic_resolve
    import pvic_pkg::*;
(
    input  line_vec_t pend_i,
    input  line_vec_t mask_i,
    input  line_vec_t isr_i,
    output logic      irq_o,
    output pick_t     win_o
);
    pick_t cand;
    pick_t serv;

    always_comb begin
        cand  = first_set(pend_i & ~mask_i);
        serv  = first_set(isr_i);
        win_o = cand;
        irq_o = cand.hit && (!serv.hit || (cand.idx < serv.idx));
    end
endmodule

// File: rtl/pvic_track.sv
module pvic_track
    import pvic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t req_i,
    input  logic      take_i,
    input  idx_t      take_idx_i,
    input  logic      eoi_i,
    output line_vec_t pend_o,
    output line_vec_t isr_o
);
    line_vec_t pend_q;
    line_vec_t isr_q;
    line_vec_t take_vec;
    line_vec_t eoi_vec;
    pick_t     top_serv;

    always_comb begin
        top_serv = first_set(isr_q);
        take_vec = one_hot(take_i, take_idx_i);
        eoi_vec  = one_hot(eoi_i && top_serv.hit, top_serv.idx);
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
                isr_q[g]  <= 1'b0;
            end else begin
                pend_q[g] <= (pend_q[g] | req_i[g]) & ~take_vec[g];
                isr_q[g]  <= (isr_q[g] & ~eoi_vec[g]) | take_vec[g];
            end
        end
    end

    assign pend_o = pend_q;
    assign isr_o  = isr_q;
endmodule

// File: rtl/prio_vec_irq_ctrl.sv
module prio_vec_irq_ctrl
    import pvic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] req_i,
    input  logic       cfg_we_i,
    input  logic       cfg_sel_i,
    input  logic [7:0] cfg_wdata_i,
    input  logic       ack_i,
    input  logic       eoi_i,
    output logic       irq_o,
    output logic [7:0] vec_o,
    output logic       vec_vld_o
);
    line_vec_t mask_q;
    base_t     base_q;
    line_vec_t pend_q;
    line_vec_t isr_q;
    pick_t     win;
    logic      irq_c;
    logic      take;
    vec_t      vec_q;
    logic      vld_q;

    pvic_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we_i   (cfg_we_i),
        .sel_i  (cfg_sel_e'(cfg_sel_i)),
        .wdata_i(cfg_wdata_i),
        .mask_o (mask_q),
        .base_o (base_q)
    );

    pvic_resolve u_resolve (
        .pend_i(pend_q),
        .mask_i(mask_q),
        .isr_i (isr_q),
        .irq_o (irq_c),
        .win_o (win)
    );

    assign take = ack_i && irq_c;

    pvic_track u_track (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .take_i    (take),
        .take_idx_i(win.idx),
        .eoi_i     (eoi_i),
        .pend_o    (pend_q),
        .isr_o     (isr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= take;
            if (take) vec_q <= {base_q, win.idx};
        end
    end

    assign irq_o     = irq_c;
    assign vec_o     = vec_q;
    assign vec_vld_o = vld_q;
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker
    import pvic_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      ack_i,
    input logic      eoi_i,
    input logic      irq_o,
    input logic      vec_vld_o,
    input line_vec_t pend,
    input line_vec_t mask,
    input line_vec_t isr
);
    p_ack_gives_vec_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o) |=> vec_vld_o);

    p_no_spurious_vec_r7: assert property (@(posedge clk) disable iff (rst)
        !(ack_i && irq_o) |=> !vec_vld_o);

    p_irq_needs_unmasked_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((pend & ~mask) != '0));

    p_ack_opens_service_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o && !eoi_i) |=> ($countones(isr) == $past($countones(isr)) + 1));

    p_eoi_closes_one_r8: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && !ack_i && (isr != '0)) |=> ($countones(isr) + 1 == $past($countones(isr))));

    p_pending_kept_r2: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> ((pend & $past(pend)) == $past(pend)));
endmodule

bind prio_vec_irq_ctrl pvic_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack_i    (ack_i),
    .eoi_i    (eoi_i),
    .irq_o    (irq_o),
    .vec_vld_o(vec_vld_o),
    .pend     (pend_q),
    .mask     (mask_q),
    .isr      (isr_q)
);

// File: tb/prio_vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_vec_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = '0;
    logic       cfg_we_i = 1'b0;
    logic       cfg_sel_i = 1'b0;
    logic [7:0] cfg_wdata_i = '0;
    logic       ack_i = 1'b0;
    logic       eoi_i = 1'b0;
    logic       irq_o;
    logic [7:0] vec_o;
    logic       vec_vld_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_pend, m_isr, m_mask;
    logic [4:0] m_base;

    always #2.5 clk = ~clk;

    prio_vec_irq_ctrl uut (
        .clk(clk), .rst(rst), .req_i(req_i), .cfg_we_i(cfg_we_i),
        .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .ack_i(ack_i),
        .eoi_i(eoi_i), .irq_o(irq_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o)
    );

    function automatic int low_idx(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic exp_irq();
        int c, s;
        c = low_idx(m_pend & ~m_mask);
        s = low_idx(m_isr);
        return (c >= 0) && (s < 0 || c < s);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] r, input logic we, input logic sel,
                        input logic [7:0] wd, input logic ak, input logic eo,
                        input string tag);
        logic ei, acc;
        int   w, s;
        logic [7:0] ev;
        @(negedge clk);
        req_i = r; cfg_we_i = we; cfg_sel_i = sel; cfg_wdata_i = wd;
        ack_i = ak; eoi_i = eo;
        #1;
        ei = exp_irq();
        check({tag, " R4 irq"}, {7'd0, irq_o}, {7'd0, ei});
        acc = ak && ei;
        w = low_idx(m_pend & ~m_mask);
        ev = {m_base, w[2:0]};
        s = low_idx(m_isr);
        if (eo && s >= 0) m_isr[s] = 1'b0;
        m_pend = m_pend | r;
        if (acc) begin
            m_pend[w] = 1'b0;
            m_isr[w]  = 1'b1;
        end
        if (we) begin
            if (sel) m_base = wd[4:0];
            else     m_mask = wd;
        end
        @(posedge clk);
        #1;
        check({tag, acc ? " R5 vld" : " R7 vld"}, {7'd0, vec_vld_o}, {7'd0, acc});
        if (acc) check({tag, " R3 R5 vec"}, vec_o, ev);
    endtask

    task automatic idle(input string tag);
        step(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic ack(input string tag);
        step(8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, tag);
    endtask

    task automatic eoi(input string tag);
        step(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, tag);
    endtask

    task automatic raise(input logic [7:0] r, input string tag);
        step(r, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_pend = '0; m_isr = '0; m_mask = '0; m_base = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 irq", {7'd0, irq_o}, 8'd0);
        check("R1 vld", {7'd0, vec_vld_o}, 8'd0);
        check("R1 vec", vec_o, 8'd0);

        // R2: short pulse survives until acknowledged
        raise(8'h20, "R2");
        idle("R2"); idle("R2");
        ack("R2");
        eoi("R2");

        // R3: several pending, lowest index wins each time
        raise(8'hA4, "R3");
        ack("R3"); eoi("R3");
        ack("R3"); eoi("R3");
        ack("R3"); eoi("R3");

        // R6: nesting, equal and lower rank blocked, higher preempts
        raise(8'h08, "R6");
        ack("R6");
        raise(8'h08, "R6");
        raise(8'h20, "R6");
        raise(8'h02, "R6");
        ack("R6");
        eoi("R6");
        eoi("R6");
        ack("R6"); eoi("R6");
        ack("R6"); eoi("R6");

        // R7: acknowledge with nothing to serve
        ack("R7");
        ack("R7");

        // R8: eoi closes only the top in-service entry
        raise(8'h10, "R8"); ack("R8");
        raise(8'h02, "R8"); ack("R8");
        eoi("R8");
        raise(8'h04, "R8");
        ack("R8");
        eoi("R8"); eoi("R8"); eoi("R8");

        // R9: masked line pending but silent, then unmasked
        step(8'h00, 1'b1, 1'b0, 8'h04, 1'b0, 1'b0, "R9");
        raise(8'h04, "R9");
        idle("R9");
        ack("R9");
        step(8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
        ack("R9");
        eoi("R9");

        // R10: base write ignores upper data bits
        step(8'h00, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, "R10");
        raise(8'h40, "R10");
        ack("R10"); eoi("R10");
        step(8'h00, 1'b1, 1'b1, 8'hE9, 1'b0, 1'b0, "R10");
        raise(8'h01, "R10");
        ack("R10"); eoi("R10");

        // Random mix
        for (int k = 0; k < 1500; k++) begin
            logic [7:0] r;
            logic we, sel, ak, eo;
            logic [7:0] wd;
            r   = (($urandom % 4) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            we  = (($urandom % 20) == 0);
            sel = 1'($urandom);
            wd  = sel ? 8'($urandom) : (8'($urandom) & 8'($urandom) & 8'($urandom));
            ak  = (($urandom % 3) == 0);
            eo  = (($urandom % 4) == 0);
            step(r, we, sel, wd, ak, eo, "RND");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule